// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the address-latch strobe and the active-low program-fetch read strobe for a classic 8-bit controller's external memory bus. It runs on the oscillator clock. A machine cycle is a fixed number of oscillator periods, and the block splits it into two equal halves, called slots. Each slot can carry one address-latch pulse, followed by one program-fetch activation.

Four control indicators describe each machine cycle:

- whether code is being fetched from external program memory;
- whether the cycle is an external data-memory access;
- whether it is a code-read instruction;
- whether the address-latch output has been switched off by its control bit.

The indicators are sampled once, on the oscillator edge that closes a machine cycle, and they shape the strobes of the whole next cycle. While the address-latch output is switched off, the block stops driving the pin so that a weak pull-up holds it high. The `ale_drv_o` output reports whether the pin is being driven strongly.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `ale_o` = 0, `ale_drv_o` = 1 and `psen_n_o` = 1. The first machine cycle after reset uses the indicator values present at the first rising edge.
- R2: A machine cycle is `CYC_LEN` (12) oscillator periods, numbered 0 to 11. With the switch-off bit clear and no data access, `ale_o` is high for `ALE_W` (2) periods starting at phase 0 and again at phase `CYC_LEN/2` (6). That gives two pulses per machine cycle, one every 6 oscillator periods.
- R3: `ext_exec_i`, `movx_i`, `movc_i` and `ale_off_i` are sampled only on the rising edge that ends phase 11. Changes at any other time have no effect on the outputs.
- R4: In a cycle whose sampled `movx_i` = 1, the slot-0 address-latch pulse is skipped: `ale_o` stays 0 and is driven. The slot-1 pulse still occurs.
- R5: If `ale_off_i` = 1, `ext_exec_i` = 0, `movx_i` = 0 and `movc_i` = 0 were sampled, then for the whole cycle `ale_drv_o` = 0 and `ale_o` = 1 (the weakly pulled-high level).
- R6: If `ale_off_i` = 1 and `ext_exec_i` = 0 were sampled with `movx_i` or `movc_i` = 1, the address-latch pulses are driven as in R2, and as in R4 when `movx_i` = 1.
- R7: If `ext_exec_i` = 1 was sampled, `ale_off_i` has no effect. The address-latch output behaves as in R2 or R4.
- R8: If `ext_exec_i` = 1 and `movx_i` = 0 were sampled, `psen_n_o` is low for `PSEN_W` (3) periods starting right after each address-latch pulse ends (phases 2..4 and 8..10), and high otherwise.
- R9: If `ext_exec_i` = 1 and `movx_i` = 1 were sampled, both program-fetch activations of that cycle are skipped and `psen_n_o` stays 1.
- R10: If `ext_exec_i` = 0 was sampled, `psen_n_o` stays 1 for the whole cycle.
- R11: A strongly driven high `ale_o` and a low `psen_n_o` never occur in the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_exec_i | input | 1 | Code is fetched from external program memory |
| movx_i | input | 1 | Machine cycle is an external data-memory access |
| movc_i | input | 1 | Machine cycle belongs to a code-read instruction |
| ale_off_i | input | 1 | Switch-off bit for the address-latch output |
| ale_o | output | 1 | Address-latch strobe level (1 while released) |
| ale_drv_o | output | 1 | 1 while the address-latch pin is strongly driven |
| psen_n_o | output | 1 | Active-low program-fetch read strobe |

## Verification
Two functions can meet in the same cycle: the skip for a data access and the switch-off of the address-latch output. Both depend on the same sampled indicators, so the cycle where the switch-off bit is set and `movx_i` is set is the contested case. In that cycle the output must be driven, with only the slot-1 pulse present.

Every combination of the four indicators is applied directly, and then random sequences follow. In the random sequences, junk values are put on the indicators in mid-cycle to confirm that only the closing edge counts. The expected value of every period is recomputed from the requirement table and compared at the falling clock edge.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;
  typedef struct packed {
    logic ext;   // external program execution
    logic movx;  // external data access cycle
    logic movc;  // code-read instruction cycle
    logic off;   // address-latch switch-off bit
  } cyc_ctx_t;

  localparam cyc_ctx_t CTX_IDLE = '{ext: 1'b0, movx: 1'b0, movc: 1'b0, off: 1'b0};
endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr #(
  parameter int CYC_LEN = 12,
  localparam int PW = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] ph_q,
  output logic [PW-1:0] ph_nxt,
  output logic          wrap
);
  localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

  assign wrap   = (ph_q == LAST);
  assign ph_nxt = wrap ? '0 : ph_q + 1'b1;

  // Reset parks at the last phase so the first edge opens machine cycle 0.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ph_q <= LAST;
    else        ph_q <= ph_nxt;

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= LAST);
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != LAST) |=> (ph_q == $past(ph_q) + 1'b1));
endmodule

// File: rtl/bus_cycle_ctx.sv
module bus_cycle_ctx
  import bus_strobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wrap,
  input  cyc_ctx_t ctx_in,
  output cyc_ctx_t ctx_q,
  output cyc_ctx_t ctx_nxt
);
  assign ctx_nxt = wrap ? ctx_in : ctx_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctx_q <= CTX_IDLE;
    else        ctx_q <= ctx_nxt;

  p_ctx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ctx_q));
endmodule

// File: rtl/bus_strobe_out.sv
module bus_strobe_out
  import bus_strobe_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int ALE_W   = 2,
  parameter int PSEN_W  = 3,
  localparam int PW     = $clog2(CYC_LEN),
  localparam int HALF   = CYC_LEN / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] ph_nxt,
  input  cyc_ctx_t      ctx_nxt,
  output logic          ale_o,
  output logic          ale_drv_o,
  output logic          psen_n_o
);
  logic          slot1;
  logic [PW-1:0] off;
  logic          ale_win, psen_win, released;
  logic          ale_d, drv_d, psen_d;

  always_comb begin
    slot1    = (ph_nxt >= PW'(HALF));
    off      = slot1 ? ph_nxt - PW'(HALF) : ph_nxt;
    ale_win  = (off < PW'(ALE_W));
    psen_win = (off >= PW'(ALE_W)) && (off < PW'(ALE_W + PSEN_W));
    released = ctx_nxt.off && !ctx_nxt.ext && !ctx_nxt.movx && !ctx_nxt.movc;
    drv_d    = !released;
    ale_d    = released | (ale_win & !(ctx_nxt.movx & !slot1));
    psen_d   = !(ctx_nxt.ext & !ctx_nxt.movx & psen_win);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ale_o     <= 1'b0;
      ale_drv_o <= 1'b1;
      psen_n_o  <= 1'b1;
    end else begin
      ale_o     <= ale_d;
      ale_drv_o <= drv_d;
      psen_n_o  <= psen_d;
    end

  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_o && ale_drv_o && !psen_n_o));
  p_release_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_drv_o |-> ale_o);
  p_psen_internal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_nxt.ext |=> psen_n_o);
  p_ext_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_nxt.ext |=> ale_drv_o);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int ALE_W   = 2,
  parameter int PSEN_W  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_exec_i,
  input  logic movx_i,
  input  logic movc_i,
  input  logic ale_off_i,
  output logic ale_o,
  output logic ale_drv_o,
  output logic psen_n_o
);
  localparam int PW   = $clog2(CYC_LEN);
  localparam int HALF = CYC_LEN / 2;

  logic [PW-1:0] ph_q, ph_nxt;
  logic          wrap;
  cyc_ctx_t      ctx_in, ctx_q, ctx_nxt;

  assign ctx_in = '{ext: ext_exec_i, movx: movx_i, movc: movc_i, off: ale_off_i};

  bus_phase_ctr #(.CYC_LEN(CYC_LEN)) u_ph (
    .clk(clk), .rst_n(rst_n), .ph_q(ph_q), .ph_nxt(ph_nxt), .wrap(wrap));

  bus_cycle_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .ctx_in(ctx_in),
    .ctx_q(ctx_q), .ctx_nxt(ctx_nxt));

  bus_strobe_out #(.CYC_LEN(CYC_LEN), .ALE_W(ALE_W), .PSEN_W(PSEN_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ph_nxt(ph_nxt), .ctx_nxt(ctx_nxt),
    .ale_o(ale_o), .ale_drv_o(ale_drv_o), .psen_n_o(psen_n_o));

  // ph_q, ctx_q and the output registers all describe the same period.
  p_ale_rise_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ale_o) && ale_drv_o) |-> (ph_q == '0 || ph_q == PW'(HALF)));
  p_data_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q.movx && ph_q == '0) |-> (ale_drv_o && !ale_o));
  p_psen_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_q.movx |-> psen_n_o);
  p_instr_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_q.movx || ctx_q.movc) |-> ale_drv_o);
endmodule

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb;
  localparam int CYC = 12, AW = 2, PSW = 3, HALF = CYC / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext = 1'b0, mx = 1'b0, mc = 1'b0, off = 1'b0;
  logic ale, drv, psen_n;
  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  bus_strobe_gen #(.CYC_LEN(CYC), .ALE_W(AW), .PSEN_W(PSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_exec_i(ext), .movx_i(mx), .movc_i(mc),
    .ale_off_i(off), .ale_o(ale), .ale_drv_o(drv), .psen_n_o(psen_n));

  // flags packed as {ext, movx, movc, off}
  function automatic logic exp_drv(logic [3:0] f);
    return !(f[0] && !f[3] && !f[2] && !f[1]);
  endfunction
  function automatic logic exp_ale(int p, logic [3:0] f);
    if (!exp_drv(f)) return 1'b1;
    if (p < AW) return !f[2];
    if (p >= HALF && p < HALF + AW) return 1'b1;
    return 1'b0;
  endfunction
  function automatic logic exp_psen(int p, logic [3:0] f);
    int o = (p >= HALF) ? p - HALF : p;
    if (!f[3] || f[2]) return 1'b1;
    return !(o >= AW && o < AW + PSW);
  endfunction
  function automatic string ale_tag(logic [3:0] f);
    if (f[0] && !f[3]) return (f[2] || f[1]) ? "R6" : "R5";
    if (f[0] && f[3]) return "R7";
    if (f[2]) return "R4";
    return "R2";
  endfunction
  function automatic string psen_tag(logic [3:0] f);
    if (!f[3]) return "R10";
    return f[2] ? "R9" : "R8";
  endfunction

  task automatic drive(logic [3:0] f);
    {ext, mx, mc, off} = f;
  endtask

  task automatic check_bit(string tag, logic act, logic expv, int p, logic [3:0] f);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s phase %0d flags %b: actual %b expected %b", tag, p, f, act, expv);
    end
  endtask

  // One machine cycle under flags fc; fn is applied for the next one.
  // When junk is set, random values sit on the inputs mid-cycle (R3).
  task automatic run_cycle(logic [3:0] fc, logic [3:0] fn, bit junk);
    for (int p = 0; p < CYC; p++) begin
      @(negedge clk);
      check_bit(junk ? {ale_tag(fc), "/R3"} : ale_tag(fc), ale, exp_ale(p, fc), p, fc);
      check_bit(junk ? {ale_tag(fc), "/R3"} : ale_tag(fc), drv, exp_drv(fc), p, fc);
      check_bit(junk ? {psen_tag(fc), "/R3"} : psen_tag(fc), psen_n, exp_psen(p, fc), p, fc);
      check_bit("R11", ale & drv & !psen_n, 1'b0, p, fc);
      if (p == CYC - 1) drive(fn);
      else if (junk) drive(4'($urandom));
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [3:0] cur, nxt;
    void'($urandom(32'h5eed_1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    check_bit("R1", ale, 1'b0, 0, 4'b0);
    check_bit("R1", drv, 1'b1, 0, 4'b0);
    check_bit("R1", psen_n, 1'b1, 0, 4'b0);
    // contested case first: switch-off with data access
    cur = 4'b0101;
    drive(cur);
    rst_n = 1'b1;
    // directed: every flag combination in sequence
    for (int i = 1; i <= 16; i++) begin
      nxt = 4'(i);
      run_cycle(cur, nxt, 1'b0);
      cur = nxt;
    end
    // random cycles with mid-cycle junk
    for (int i = 0; i < 300; i++) begin
      nxt = 4'($urandom);
      run_cycle(cur, nxt, 1'b1);
      cur = nxt;
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule